// File: doc/BRIEF.md
# Fracturable LUT Logic Element

This block is a small programmable logic cell. Seven data inputs feed a 64-bit truth table that works either as one 6-input lookup or as two 5-input lookups whose input windows overlap: the low lookup reads inputs 0 to 4 and the high lookup reads inputs 2 to 6. Each lookup result has its own flip-flop on the cell clock. A per-output select bit then presents either the stored value or the live combinational value.

The whole configuration is loaded one bit per clock through a serial shift chain while the configuration enable is high. That configuration is the truth table, the mode bit and the two output selects. While the chain shifts, both flip-flops keep their contents. A synchronous reset clears the flip-flops and leaves the configuration alone.

Top module: `fle_logic_element`

## Requirements
- R1: While `cfg_en` is high, each rising clock shifts `cfg_in` into a 67-bit chain, least significant bit first. After 67 shifts the first bit sent sits at position 0. Positions 63..0 hold the truth table, position 64 the mode (0 = one 6-input lookup, 1 = two 5-input lookups), position 65 the select of output 0 and position 66 the select of output 1 (0 = combinational, 1 = registered). While `cfg_en` is low the chain does not change.
- R2: In single mode, the combinational value of output 0 is truth-table bit `din[5:0]`, and `din[6]` has no effect.
- R3: In single mode, the combinational value of output 1 is 0.
- R4: In dual mode, the combinational value of output 0 is truth-table bit `{1'b0, din[4:0]}`, which lies in the lower 32 bits.
- R5: In dual mode, the combinational value of output 1 is truth-table bit `32 + din[6:2]`.
- R6: While `rst` and `cfg_en` are both low, flip-flop k captures the combinational value of lookup k at each rising edge. With select k set, `dout[k]` shows that captured value during the following cycle.
- R7: The two output selects act independently, so one output can be registered while the other is combinational.
- R8: While `cfg_en` is high, both flip-flops hold their value.
- R9: `rst` high at a rising edge clears both flip-flops, even when `cfg_en` is also high. It does not change the configuration chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock for the flip-flops and the configuration chain |
| rst | input | 1 | Synchronous active-high clear of the two flip-flops |
| cfg_en | input | 1 | Shift enable of the configuration chain; flip-flops hold while high |
| cfg_in | input | 1 | Serial configuration bit, least significant first |
| din | input | 7 | Logic inputs |
| dout | output | 2 | Cell outputs, each registered or combinational per its select |

## Verification
Reset and configuration shifting can fall in the same cycle, and they act on different state: the reset clears the flip-flops while the chain keeps moving. The bench raises reset for one cycle in the middle of a 67-bit load whose new configuration registers output 0 and leaves output 1 combinational. On the first cycle after the load, output 0 must read zero, because the flip-flops were cleared and then held. Output 1 must at the same time follow the newly loaded truth table, which shows that the reset left the shift undisturbed.

// File: rtl/fle_pkg.sv
package fle_pkg;

    // Lookup arrangement selected by the mode bit of the configuration.
    typedef enum logic {
        FRAC_SINGLE = 1'b0,
        FRAC_DUAL   = 1'b1
    } frac_mode_e;

    // Source presented on one output pin.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_src_e;

    // Default geometry of the cell.
    localparam int unsigned DEF_N_IN  = 7;
    localparam int unsigned DEF_LUT_K = 6;
    localparam int unsigned N_OUT     = 2;

    // Chain length for a given lookup size: table, mode bit, one select per output.
    function automatic int unsigned chain_len(input int unsigned lut_k);
        return (1 << lut_k) + 1 + N_OUT;
    endfunction

endpackage

// File: rtl/fle_cfg_chain.sv
module fle_cfg_chain #(
    parameter int unsigned CHAIN_W = 67
) (
    input  logic               clk,
    input  logic               cfg_en,
    input  logic               cfg_in,
    output logic [CHAIN_W-1:0] cfg_q
);

    // New bits enter at the top and move down, so the first bit sent ends at position 0.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            cfg_q <= {cfg_in, cfg_q[CHAIN_W-1:1]};
        end
    end

endmodule

// File: rtl/fle_lut_core.sv
module fle_lut_core
    import fle_pkg::*;
#(
    parameter int unsigned N_IN  = 7,
    parameter int unsigned LUT_K = 6,
    localparam int unsigned TT_W  = 1 << LUT_K,
    localparam int unsigned SUB_K = LUT_K - 1
) (
    input  logic [N_IN-1:0]  din,
    input  logic [TT_W-1:0]  table_bits,
    input  frac_mode_e       mode,
    output logic [N_OUT-1:0] lut_y
);

    logic [LUT_K-1:0] addr_lo;
    logic [LUT_K-1:0] addr_hi;

    always_comb begin
        // Low half uses the bottom inputs; high half uses the top SUB_K inputs.
        addr_lo = {1'b0, din[SUB_K-1:0]};
        addr_hi = {1'b1, din[N_IN-1 -: SUB_K]};
        if (mode == FRAC_DUAL) begin
            lut_y[0] = table_bits[addr_lo];
            lut_y[1] = table_bits[addr_hi];
        end else begin
            lut_y[0] = table_bits[din[LUT_K-1:0]];
            lut_y[1] = 1'b0;
        end
    end

endmodule

// File: rtl/fle_out_stage.sv
module fle_out_stage
    import fle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [N_OUT-1:0] lut_y,
    input  logic [N_OUT-1:0] sel,
    output logic [N_OUT-1:0] ff_q,
    output logic [N_OUT-1:0] dout
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_lane
        // The clear wins over the configuration hold.
        always_ff @(posedge clk) begin
            if (rst) begin
                ff_q[k] <= 1'b0;
            end else if (!hold) begin
                ff_q[k] <= lut_y[k];
            end
        end

        assign dout[k] = (out_src_e'(sel[k]) == OUT_REG) ? ff_q[k] : lut_y[k];
    end

endmodule

// File: rtl/fle_logic_element.sv
module fle_logic_element
    import fle_pkg::*;
#(
    parameter int unsigned N_IN  = DEF_N_IN,
    parameter int unsigned LUT_K = DEF_LUT_K,
    localparam int unsigned TT_W     = 1 << LUT_K,
    localparam int unsigned CHAIN_W  = chain_len(LUT_K),
    localparam int unsigned MODE_POS = TT_W,
    localparam int unsigned SEL_LO   = TT_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_in,
    input  logic [N_IN-1:0] din,
    output logic [N_OUT-1:0] dout
);

    logic [CHAIN_W-1:0] cfg_q;
    frac_mode_e         mode;
    logic [N_OUT-1:0]   sel_bits;
    logic [N_OUT-1:0]   lut_y;
    logic [N_OUT-1:0]   ff_q;

    fle_cfg_chain #(
        .CHAIN_W (CHAIN_W)
    ) u_chain (
        .clk    (clk),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    assign mode     = frac_mode_e'(cfg_q[MODE_POS]);
    assign sel_bits = cfg_q[SEL_LO +: N_OUT];

    fle_lut_core #(
        .N_IN  (N_IN),
        .LUT_K (LUT_K)
    ) u_lut (
        .din        (din),
        .table_bits (cfg_q[TT_W-1:0]),
        .mode       (mode),
        .lut_y      (lut_y)
    );

    fle_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .hold  (cfg_en),
        .lut_y (lut_y),
        .sel   (sel_bits),
        .ff_q  (ff_q),
        .dout  (dout)
    );

endmodule

// File: rtl/fle_chk.sv
module fle_chk
    import fle_pkg::*;
#(
    parameter int unsigned CHAIN_W = 67
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_en,
    input logic               cfg_in,
    input logic [CHAIN_W-1:0] cfg_q,
    input frac_mode_e         mode,
    input logic [N_OUT-1:0]   sel_bits,
    input logic [N_OUT-1:0]   lut_y,
    input logic [N_OUT-1:0]   ff_q,
    input logic [N_OUT-1:0]   dout
);

    // R1
    chain_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_q[CHAIN_W-1] == $past(cfg_in));

    // R1
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));

    // R3
    single_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FRAC_SINGLE && !sel_bits[1]) |-> dout[1] == 1'b0);

    // R6
    ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> ff_q == $past(lut_y));

    // R8
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(ff_q));

    // R9
    ff_clear_chk: assert property (@(posedge clk)
        rst |=> ff_q == '0);

endmodule

bind fle_logic_element fle_chk #(
    .CHAIN_W (CHAIN_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .mode     (mode),
    .sel_bits (sel_bits),
    .lut_y    (lut_y),
    .ff_q     (ff_q),
    .dout     (dout)
);

// File: tb/fle_logic_element_tb.sv
module fle_logic_element_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 67;

    typedef struct {
        int         cyc;
        logic [1:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [6:0] din = '0;
    logic [1:0] dout;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    logic [CW-1:0] mcfg = '0;
    logic [1:0]    ffm = '0;

    fle_logic_element u_dut (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .din    (din),
        .dout   (dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected lookup values from R2..R5.
    function automatic logic [1:0] model(input logic [CW-1:0] w, input logic [6:0] d);
        logic [63:0] tt;
        tt = w[63:0];
        if (w[64]) return {tt[32 + int'(d[6:2])], tt[int'(d[4:0])]};
        return {1'b0, tt[int'(d[5:0])]};
    endfunction

    function automatic logic [CW-1:0] mkcfg(input logic sel1, input logic sel0,
                                             input logic dual, input logic [63:0] tt);
        return {sel1, sel0, dual, tt};
    endfunction

    // Serial load; rst is pulsed on shift index rst_at (negative: never).
    task automatic load(input logic [CW-1:0] w, input int rst_at);
        for (int i = 0; i < CW; i++) begin
            @(posedge clk); #1;
            cfg_en = 1'b1;
            cfg_in = w[i];
            rst    = (i == rst_at);
            if (i == rst_at) ffm = '0;
        end
        mcfg = w;
    endtask

    // Drive one input vector and queue the output expected in this cycle.
    task automatic step(input logic [6:0] d, input string tag);
        logic [1:0] comb;
        item_t it;
        @(posedge clk); #1;
        cfg_en = 1'b0;
        cfg_in = 1'b0;
        rst    = 1'b0;
        din    = d;
        comb   = model(mcfg, d);
        it.cyc = cyc;
        it.tag = tag;
        it.exp[0] = mcfg[65] ? ffm[0] : comb[0];
        it.exp[1] = mcfg[66] ? ffm[1] : comb[1];
        sb_q.push_back(it);
        ffm = comb;
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        ffm = '0;
    endtask

    // Monitor: compare every item due in this cycle at the falling edge.
    always @(negedge clk) begin
        int i = 0;
        while (i < sb_q.size()) begin
            if (sb_q[i].cyc == cyc) begin
                checks++;
                if (dout !== sb_q[i].exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d din=%h actual=%b expected=%b",
                             sb_q[i].tag, cyc, din, dout, sb_q[i].exp);
                end
                sb_q.delete(i);
            end else begin
                i++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] tt_a;
        logic [63:0] tt_b;
        tt_a = 64'h9E37_79B9_7F4A_7C15;
        tt_b = 64'hC2B2_AE3D_27D4_EB4F;
        repeat (3) @(posedge clk);

        // R1 R2 R3: single mode, both outputs combinational
        load(mkcfg(1'b0, 1'b0, 1'b0, tt_a), 0);
        step(7'h00, "R1 R2 R3 single");
        step(7'h3F, "R2 R3 single");
        step(7'h15, "R2 R3 single");
        step(7'h55, "R2 single din6 ignored");
        step(7'h6A, "R2 R3 single din6 ignored");
        step(7'h2A, "R2 single");

        // R4 R5: dual mode, overlapping windows
        load(mkcfg(1'b0, 1'b0, 1'b1, tt_b), -1);
        step(7'h00, "R1 R4 R5 dual");
        step(7'h7F, "R4 R5 dual");
        step(7'h1F, "R4 R5 dual");
        step(7'h60, "R4 R5 dual");
        step(7'h33, "R4 R5 dual");
        step(7'h55, "R4 R5 dual");

        // R8: first cycle after a registered reload shows the held value
        load(mkcfg(1'b1, 1'b1, 1'b1, tt_b), -1);
        step(7'h0C, "R8 hold during load");
        step(7'h71, "R6 registered");
        step(7'h2E, "R6 registered");
        step(7'h49, "R6 registered");
        step(7'h16, "R6 registered");

        // R9: reset clears registers, configuration stays
        pulse_reset();
        step(7'h5B, "R9 reset clears");
        step(7'h07, "R9 R6 config kept");
        step(7'h68, "R9 R6 config kept");

        // R9 with shift in the same cycle, then R7 mixed selects
        load(mkcfg(1'b0, 1'b1, 1'b1, tt_a), 30);
        step(7'h3C, "R9 reset during shift");
        step(7'h41, "R7 mixed select");
        step(7'h1E, "R7 mixed select");
        step(7'h77, "R7 mixed select");

        // R7 R3: single mode, output 1 registered, output 0 combinational
        load(mkcfg(1'b1, 1'b0, 1'b0, tt_b), -1);
        step(7'h12, "R7 R3 single reg hi");
        step(7'h3B, "R7 R3 single reg hi");
        step(7'h64, "R7 R3 single reg hi");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R6 scoreboard left %0d items, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule